// File: doc/BRIEF.md
# Error-Tolerant Sync Hunter and Packet Deframer

This block is the bit-level receive front end for a low-rate signalling packet. It accepts one received bit per `bit_valid` strobe and first hunts for the end of a preamble: a run of at least nineteen zero bits closed by a one. Once that is seen it switches to differential decoding. Each decoded bit is the running XOR of the previous decoded bit and the new raw bit. It then searches the decoded stream for a 40-bit sync word, in either true or complemented form, and accepts up to eight disagreeing bits.

The polarity found at lock is latched and inverts every later decoded bit. After lock the block gathers fourteen payload bytes and hands them to an external decoder. The handshake is a one-cycle `dec_start` pulse, followed later by a `dec_done` pulse that carries a CRC verdict. A good verdict produces a one-cycle `pkt_valid` with opcode, argument and a 16-bit unit ID. Either verdict returns the receiver to a fully cleared hunt.

Top module: `sig_deframer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `dec_start` and `pkt_valid` are 0. `pkt_opcode`, `pkt_arg`, `pkt_unit` and `dec_bytes` are all zero.
- R2: The hunt ends on the accepted bit that meets two conditions together: at least 20 bits have been counted since the hunt began, and the last 20 raw bits are 0x00001 (nineteen zeros, then a one). With only 19 bits counted the hunt continues.
- R3: After the hunt ends, each accepted raw bit r gives a decoded bit d = p XOR r XOR v. Here p is the previous decoded bit, which is set to 1 by the bit that ended the hunt. v is the latched polarity flag, which is 0 until lock.
- R4: The bit that ends the hunt counts as 1. A sync comparison is made only on decoded bits whose count reaches 32 or more.
- R5: The sync window is the last 40 history bits. Lock needs at least 32 of them to agree with 0x07092A446F or with its complement. Inverted polarity is latched only when the complement agreement is strictly larger.
- R6: After lock, each group of 8 decoded bits forms one byte, with the first received bit as bit 7. Byte k (0 to 13) appears on `dec_bytes[8k+7:8k]`.
- R7: The bit that completes byte 13 raises `dec_start` for exactly one cycle, starting on the next clock edge. From then until `dec_done`, `bit_valid` strobes are ignored and `dec_bytes` holds still.
- R8: `dec_done` with `dec_crc_ok`=0 produces no `pkt_valid`. It clears all receive state, including the bit count and the bit history, so a new preamble needs 20 fresh bits.
- R9: `dec_done` with `dec_crc_ok`=1 raises `pkt_valid` for exactly one cycle on the next edge. The outputs are then `pkt_opcode` = byte 0, `pkt_arg` = byte 1 and `pkt_unit` = {byte 3, byte 2}. The receiver then returns to a cleared hunt.
- R10: A sync word with 8 flipped bits still locks, in either polarity. With 9 flipped bits it never locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received raw bit, most significant bit of each byte first |
| dec_start | output | 1 | One-cycle request to the decoder; payload is ready |
| dec_bytes | output | 112 | Gathered payload, byte k at bits 8k+7:8k |
| dec_done | input | 1 | One-cycle decoder completion |
| dec_crc_ok | input | 1 | CRC verdict, valid with `dec_done` |
| pkt_valid | output | 1 | One-cycle pulse: packet fields are new |
| pkt_opcode | output | 8 | Payload byte 0 |
| pkt_arg | output | 8 | Payload byte 1 |
| pkt_unit | output | 16 | Unit ID, byte 3 high, byte 2 low |

## Verification
The bench goes after the edges of the lock decision. One case is a sync word with eight flipped bits, which must lock; a threshold that is off by one would drop it. Another is nine flipped bits, which must not lock; a loose threshold would start a decode on noise. A complemented sync word must lock with inverted polarity; a design that ignores polarity would deliver every payload bit inverted.

The preamble is exercised with exactly 20 and with only 19 counted bits. A hunt that skips the bit count, or a failure path that leaves the count uncleared, would lock on the short preamble.

Random payloads are sent with random strobe gaps, and junk bits arrive while the decoder is busy. A gatherer that misaligns its byte boundaries would show up in the `dec_bytes` comparison. One that keeps listening while the decoder works would corrupt the reported fields.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int SYNC_W   = 40;
    localparam int SYNC_MIN = 32;
    localparam int PRE_W    = 20;
    localparam int PRE_MIN  = 20;
    localparam int NBYTES   = 14;
    localparam int BYTE_W   = 8;

    localparam logic [SYNC_W-1:0] SYNC_WORD = 40'h07092A446F;
    localparam logic [PRE_W-1:0]  PRE_END   = 20'h00001;

    // history keeps one bit fewer than the window; the newest bit completes it
    localparam int HIST_W = SYNC_W - 1;
    localparam int CNT_W  = $clog2(2 * SYNC_W + 1);
    localparam int AGR_W  = $clog2(SYNC_W + 1);

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_GATHER = 2'd2,
        ST_DECODE = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [7:0]  arg;
        logic [15:0] unit;
    } pkt_s;

    function automatic logic [AGR_W-1:0] agree_count(logic [SYNC_W-1:0] a,
                                                     logic [SYNC_W-1:0] b);
        return AGR_W'($countones(~(a ^ b)));
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
        return (&c) ? c : c + 1'b1;
    endfunction

endpackage

// File: rtl/sdf_diff_bit.sv
module sdf_diff_bit (
    input  logic hunting,
    input  logic prev_q,
    input  logic inv_q,
    input  logic raw,
    output logic dec_bit
);
    // raw pass-through while hunting, running XOR (with polarity) otherwise
    always_comb begin
        if (hunting) dec_bit = raw;
        else         dec_bit = prev_q ^ raw ^ inv_q;
    end
endmodule

// File: rtl/sdf_sync_match.sv
module sdf_sync_match import sdf_pkg::*; #(
    parameter int                W     = SYNC_W,
    parameter int                NEED  = SYNC_MIN,
    parameter logic [SYNC_W-1:0] WORD  = SYNC_WORD
) (
    input  logic [W-1:0] window,
    output logic         found,
    output logic         inverted
);
    logic [AGR_W-1:0] agr_true;
    logic [AGR_W-1:0] agr_comp;

    always_comb begin
        agr_true = agree_count(window, WORD);
        agr_comp = agree_count(window, ~WORD);
        found    = (agr_true >= AGR_W'(NEED)) || (agr_comp >= AGR_W'(NEED));
        inverted = agr_comp > agr_true;
    end
endmodule

// File: rtl/sdf_byte_store.sv
module sdf_byte_store import sdf_pkg::*; #(
    parameter int N  = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    output logic          last_slot,
    output logic [N*BW-1:0] bytes_flat
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] idx_q;

    assign last_slot = (idx_q == IDX_W'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)  idx_q <= '0;
        else if (wr)       idx_q <= last_slot ? '0 : idx_q + 1'b1;
    end

    for (genvar k = 0; k < N; k++) begin : g_slot
        logic [BW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || clear)                      slot_q <= '0;
            else if (wr && idx_q == IDX_W'(k))     slot_q <= wdata;
        end
        assign bytes_flat[k*BW +: BW] = slot_q;
    end

    // R6: the write index never leaves the payload range
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(N));
endmodule

// File: rtl/sig_deframer.sv
module sig_deframer import sdf_pkg::*; #(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_valid,
    input  logic           bit_in,
    output logic           dec_start,
    output logic [NB*BW-1:0] dec_bytes,
    input  logic           dec_done,
    input  logic           dec_crc_ok,
    output logic           pkt_valid,
    output logic [7:0]     pkt_opcode,
    output logic [7:0]     pkt_arg,
    output logic [15:0]    pkt_unit
);
    rx_state_e         st;
    logic [HIST_W-1:0] hist_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              prev_q;
    logic              inv_q;
    pkt_s              pkt_q;

    logic              dec_bit;
    logic [SYNC_W-1:0] window;
    logic [CNT_W-1:0]  cnt_nx;
    logic              step;
    logic              sync_found;
    logic              sync_inv;
    logic              store_wr;
    logic              store_last;
    logic              wipe;

    assign step     = bit_valid && (st != ST_DECODE);
    assign window   = {hist_q, dec_bit};
    assign cnt_nx   = sat_inc(cnt_q);
    assign store_wr = step && (st == ST_GATHER) && (cnt_nx == CNT_W'(BW));
    assign wipe     = (st == ST_DECODE) && dec_done;

    sdf_diff_bit u_diff (
        .hunting (st == ST_HUNT),
        .prev_q  (prev_q),
        .inv_q   (inv_q),
        .raw     (bit_in),
        .dec_bit (dec_bit)
    );

    sdf_sync_match u_match (
        .window   (window),
        .found    (sync_found),
        .inverted (sync_inv)
    );

    sdf_byte_store #(.N(NB), .BW(BW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (wipe),
        .wr         (store_wr),
        .wdata      (window[BW-1:0]),
        .last_slot  (store_last),
        .bytes_flat (dec_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HUNT;
            hist_q    <= '0;
            cnt_q     <= '0;
            prev_q    <= 1'b0;
            inv_q     <= 1'b0;
            dec_start <= 1'b0;
            pkt_valid <= 1'b0;
            pkt_q     <= '0;
        end else begin
            dec_start <= 1'b0;
            pkt_valid <= 1'b0;
            unique case (st)
                ST_HUNT: if (step) begin
                    hist_q <= window[HIST_W-1:0];
                    if (cnt_nx >= CNT_W'(PRE_MIN) && window[PRE_W-1:0] == PRE_END) begin
                        prev_q <= 1'b1;
                        cnt_q  <= CNT_W'(1);
                        st     <= ST_SYNC;
                    end else begin
                        prev_q <= dec_bit;
                        cnt_q  <= cnt_nx;
                    end
                end
                ST_SYNC: if (step) begin
                    hist_q <= window[HIST_W-1:0];
                    prev_q <= dec_bit;
                    if (cnt_nx >= CNT_W'(SYNC_MIN) && sync_found) begin
                        inv_q <= sync_inv;
                        cnt_q <= '0;
                        st    <= ST_GATHER;
                    end else begin
                        cnt_q <= cnt_nx;
                    end
                end
                ST_GATHER: if (step) begin
                    hist_q <= window[HIST_W-1:0];
                    prev_q <= dec_bit;
                    if (store_wr) begin
                        cnt_q <= '0;
                        if (store_last) begin
                            st        <= ST_DECODE;
                            dec_start <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_nx;
                    end
                end
                ST_DECODE: if (dec_done) begin
                    if (dec_crc_ok) begin
                        pkt_valid    <= 1'b1;
                        pkt_q.opcode <= dec_bytes[0*BW +: 8];
                        pkt_q.arg    <= dec_bytes[1*BW +: 8];
                        pkt_q.unit   <= {dec_bytes[3*BW +: 8], dec_bytes[2*BW +: 8]};
                    end
                    st     <= ST_HUNT;
                    hist_q <= '0;
                    cnt_q  <= '0;
                    prev_q <= 1'b0;
                    inv_q  <= 1'b0;
                end
                default: st <= ST_HUNT;
            endcase
        end
    end

    assign pkt_opcode = pkt_q.opcode;
    assign pkt_arg    = pkt_q.arg;
    assign pkt_unit   = pkt_q.unit;

    // R2: no hunt exit before the bit count can reach the minimum
    assert_hunt_min_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT && cnt_q < CNT_W'(PRE_MIN - 1)) |=> (st != ST_SYNC));

    // R4: no lock while the count is still below the comparison threshold
    assert_no_early_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SYNC && cnt_q < CNT_W'(SYNC_MIN - 1)) |=> (st != ST_GATHER));

    // R7: start is a single-cycle pulse
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dec_start |=> !dec_start);

    // R7: payload frozen while the decoder works
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE && !dec_done) |=> $stable(dec_bytes));

    // R8: a bad verdict returns to the hunt with no packet pulse
    assert_fail_rehunt_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE && dec_done && !dec_crc_ok) |=> (st == ST_HUNT && !pkt_valid));

    // R9: a packet pulse only follows a good verdict
    assert_valid_src_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> $past(dec_done && dec_crc_ok));
endmodule

// File: tb/sig_deframer_test.sv
module sig_deframer_test;
    localparam logic [39:0] SYNC = 40'h07092A446F;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bit_valid = 1'b0;
    logic         bit_in = 1'b0;
    logic         dec_start;
    logic [111:0] dec_bytes;
    logic         dec_done = 1'b0;
    logic         dec_crc_ok = 1'b0;
    logic         pkt_valid;
    logic [7:0]   pkt_opcode;
    logic [7:0]   pkt_arg;
    logic [15:0]  pkt_unit;

    int n_run  = 0;
    int n_fail = 0;
    int starts = 0;
    int gapmax = 0;
    logic prev_d = 1'b0;
    logic inv_e  = 1'b0;

    always #4 clk = ~clk;

    sig_deframer uut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .dec_start(dec_start), .dec_bytes(dec_bytes),
        .dec_done(dec_done), .dec_crc_ok(dec_crc_ok),
        .pkt_valid(pkt_valid), .pkt_opcode(pkt_opcode),
        .pkt_arg(pkt_arg), .pkt_unit(pkt_unit)
    );

    always @(negedge clk) if (dec_start) starts++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        int g;
        g = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
        repeat (g) begin @(posedge clk); #1; end
        bit_valid = 1'b1;
        bit_in    = b;
        @(posedge clk); #1;
        bit_valid = 1'b0;
        bit_in    = 1'($urandom);
    endtask

    task automatic put_dec(input logic d);
        logic r;
        r = d ^ prev_d ^ inv_e;
        prev_d = d;
        put_bit(r);
    endtask

    task automatic send_pre(input int nzero);
        for (int i = 0; i < nzero; i++) put_bit(1'b0);
        put_bit(1'b1);
        prev_d = 1'b1;
        inv_e  = 1'b0;
    endtask

    task automatic send_sync(input logic pol, input int nerr);
        logic [39:0] w;
        w = pol ? ~SYNC : SYNC;
        for (int i = 0; i < nerr; i++) w[i*4] = ~w[i*4];
        for (int i = 39; i >= 0; i--) put_dec(w[i]);
        inv_e = pol;
    endtask

    task automatic send_payload(input logic [111:0] p);
        for (int k = 0; k < 14; k++)
            for (int b = 7; b >= 0; b--) put_dec(p[8*k + b]);
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // full packet, decoder model and expected-field checks
    task automatic run_pkt(input logic [111:0] p, input logic pol, input int nerr,
                           input logic ok, input int junk, input int npre);
        int s0;
        s0 = starts;
        send_pre(npre);
        send_sync(pol, nerr);
        send_payload(p);
        chk(dec_start === 1'b1, "R7", "start after byte 13", 128'(dec_start), 128'(1));
        chk(starts == s0, "R7", "no earlier start", 128'(starts), 128'(s0));
        chk(dec_bytes === p, pol ? "R6 R3 R5 inverted" : "R6 R3 R5", "payload bytes",
            128'(dec_bytes), 128'(p));
        for (int j = 0; j < junk; j++) put_bit(1'($urandom));
        dec_done = 1'b1;
        dec_crc_ok = ok;
        @(posedge clk); #1;
        dec_done = 1'b0;
        chk(pkt_valid === ok, ok ? "R9" : "R8", "pkt_valid on verdict", 128'(pkt_valid), 128'(ok));
        if (ok) begin
            chk(pkt_opcode === p[7:0], "R9", "opcode", 128'(pkt_opcode), 128'(p[7:0]));
            chk(pkt_arg === p[15:8], "R9", "arg", 128'(pkt_arg), 128'(p[15:8]));
            chk(pkt_unit === {p[31:24], p[23:16]}, "R9", "unit id",
                128'(pkt_unit), 128'({p[31:24], p[23:16]}));
        end
        @(posedge clk); #1;
        chk(pkt_valid === 1'b0, "R9", "single-cycle valid", 128'(pkt_valid), 128'(0));
        chk(starts == s0 + 1, "R7", "one start per packet", 128'(starts), 128'(s0 + 1));
    endtask

    // stream that must not produce a decode request
    task automatic expect_silence(input string req, input string what);
        int s0;
        s0 = starts;
        send_sync(1'b0, 0);
        send_payload({14{8'h55}});
        repeat (20) @(posedge clk);
        #1;
        chk(starts == s0, req, what, 128'(starts), 128'(s0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] rnd;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(dec_start === 1'b0 && pkt_valid === 1'b0, "R1", "pulses in reset",
            128'({dec_start, pkt_valid}), 128'(0));
        rst = 1'b0;
        @(posedge clk); #1;
        chk({pkt_opcode, pkt_arg, pkt_unit} === 32'h0, "R1", "fields after reset",
            128'({pkt_opcode, pkt_arg, pkt_unit}), 128'(0));
        chk(dec_bytes === 112'h0 && dec_start === 1'b0, "R1", "payload after reset",
            128'(dec_bytes), 128'(0));

        // directed: minimum preamble and a known packet
        run_pkt(112'h0000_0000_0000_0000_0000_3412_8001, 1'b0, 0, 1'b1, 0, 19);

        // directed: 19 counted bits only, hunt must continue (R2)
        pulse_reset();
        send_pre(18);
        expect_silence("R2", "no lock on 19-bit preamble");
        pulse_reset();

        // directed: tolerance edges (R10)
        run_pkt(112'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A, 1'b0, 8, 1'b1, 3, 23);
        run_pkt(112'hFEDC_BA98_7654_3210_A5A5_5A5A_C3C3, 1'b1, 8, 1'b1, 2, 23);
        send_pre(23);
        begin
            int s0;
            s0 = starts;
            send_sync(1'b0, 9);
            send_payload({14{8'h55}});
            repeat (20) @(posedge clk);
            #1;
            chk(starts == s0, "R10", "no lock with 9 errors", 128'(starts), 128'(s0));
        end
        pulse_reset();

        // directed: bad verdict, then cleared count (R8)
        run_pkt(112'h1111_2222_3333_4444_5555_6666_7777, 1'b1, 0, 1'b0, 4, 23);
        send_pre(18);
        expect_silence("R8", "count cleared after failure");
        pulse_reset();
        run_pkt(112'h9999_8888_7777_6666_5555_4444_3333, 1'b0, 0, 1'b1, 0, 19);

        // random packets with gaps and busy-time junk
        gapmax = 2;
        for (int n = 0; n < 10; n++) begin
            rnd = {$urandom, $urandom, $urandom, $urandom};
            run_pkt(rnd[111:0], 1'($urandom), int'($urandom % 9),
                    ($urandom % 4) != 0, int'($urandom % 6), 19 + int'($urandom % 6));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule